// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two conditions into a clean system reset. One input is a supply-good flag, already synchronized to the clock, that stands in for a supply-threshold comparator. The other is an active-low manual reset request, which may come straight from a push-button. Reset stays asserted while the supply is bad or the button is held. Once both causes have gone away, reset is held for a further fixed number of clock cycles and then released.

The stretch counter reloads in every cycle in which a cause is present. A brownout that arrives in the middle of a stretch therefore starts the full interval again, and contact bounce on the button is absorbed without a separate debouncer. The stretch length is a parameter in clock cycles. The default of 10,000,000 cycles gives 200 ms at a 50 MHz clock, which lies inside the 140 ms to 280 ms window a supervisor must respect. A simulation can use a short value and the behaviour stays the same.

Two output flops drive the active-low reset and its active-high complement. The block's own synchronous reset models power-on.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_ok` is sampled low at a clock edge, `rst_n_out` is 0 after that edge.
- R2: When `supply_ok` is 1 and no manual request is active, `rst_n_out` returns to 1 exactly STRETCH_CYC edges after the first edge at which no cause is sampled.
- R3: The stretch has the same length whichever cause cleared last. For the manual cause it is counted from the synchronized view of `mr_n`, so the synchronizer adds 2 edges.
- R4: `mr_n` is active low. A low level is seen 2 edges later through a two-flop synchronizer. From then on `rst_n_out` is 0 for as long as it stays low.
- R5: A cause that appears during a stretch, including one in the very cycle the stretch would end, keeps reset asserted and restarts the full STRETCH_CYC interval from its removal.
- R6: `rst_out` is always the exact inverse of `rst_n_out`.
- R7: While `rst` is 1 the outputs show reset asserted (`rst_n_out`=0, `rst_out`=1). After `rst` falls, the stretch begins only once `supply_ok` is seen high.
- R8: Bounce on `mr_n`, made of low/high runs each shorter than STRETCH_CYC, yields one continuous reset pulse. It ends STRETCH_CYC+2 edges after the last rise of `mr_n`.
- R9: With both causes present, release is timed from whichever of the two clears last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| supply_ok | input | 1 | Synchronized supply-above-threshold flag, 1 = good |
| mr_n | input | 1 | Asynchronous manual reset request, active low |
| rst_n_out | output | 1 | System reset, active low, registered |
| rst_out | output | 1 | System reset, active high, registered complement |

## Verification
Two functions can fall in the same cycle: the end of a stretch and the arrival of a new cause. The bench provokes this by dropping `supply_ok` exactly at the edge where the count would have released reset. It then judges that reset never releases and that a full new interval follows. A second collision releases both causes on the same clock edge. Here the release must follow the later, synchronized manual path at STRETCH_CYC+2 edges.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Width of a down-counter that must hold the value n.
  function automatic int unsigned cnt_width(input longint unsigned n);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= n) w++;
    return w;
  endfunction

  // Active-level encodings used across the block.
  localparam logic RST_ASSERTED_N = 1'b0;
  localparam logic RST_ASSERTED   = 1'b1;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= RST_VAL;
        else if (g == 0) chain_q[g] <= d_in;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic hold_next
);
  localparam int unsigned CW = cnt_width(STRETCH_CYC);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cause) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold_next = cause | (cnt_q != '0);

  // Check-only run counter: edges since a cause was last seen.
  logic [CW-1:0] clr_run_q;
  always_ff @(posedge clk) begin
    if (rst || cause) clr_run_q <= '0;
    else if (clr_run_q != LOAD) clr_run_q <= clr_run_q + 1'b1;
  end

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    cause |=> (cnt_q == LOAD));

  assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
    (!cause && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_stretch_len_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> ((cnt_q + clr_run_q) == LOAD));
endmodule

// File: rtl/supv_outreg.sv
module supv_outreg
  import supv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_next,
  output logic lo_n_q,
  output logic hi_q
);
  always_ff @(posedge clk) begin
    if (rst) lo_n_q <= RST_ASSERTED_N;
    else     lo_n_q <= ~hold_next;
  end

  always_ff @(posedge clk) begin
    if (rst) hi_q <= RST_ASSERTED;
    else     hi_q <= hold_next;
  end

  assert_complement_R6: assert property (@(posedge clk) disable iff (rst)
    hi_q == ~lo_n_q);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 10_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic mr_n,
  output logic rst_n_out,
  output logic rst_out
);
  logic mr_n_sync;
  logic cause;
  logic hold_next;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst(rst), .d_in(mr_n), .q_out(mr_n_sync)
  );

  assign cause = ~supply_ok | ~mr_n_sync;

  supv_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk(clk), .rst(rst), .cause(cause), .hold_next(hold_next)
  );

  supv_outreg u_out (
    .clk(clk), .rst(rst), .hold_next(hold_next),
    .lo_n_q(rst_n_out), .hi_q(rst_out)
  );

  assert_supply_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !rst_n_out);

  assert_manual_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !mr_n_sync |=> !rst_n_out);

  assert_poweron_R7: assert property (@(posedge clk)
    rst |=> (!rst_n_out && rst_out));
endmodule

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;
  localparam int S = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic rst_n_out, rst_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  supv_reset_gen #(.STRETCH_CYC(S)) u0 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_n(mr_n),
    .rst_n_out(rst_n_out), .rst_out(rst_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_active(input string req);
    chk(rst_n_out == 1'b0, req, rst_n_out, 0);
    chk(rst_out == ~rst_n_out, "R6", rst_out, ~rst_n_out);
  endtask

  // Counts negedge samples with reset asserted until release.
  task automatic meas(output int n);
    n = 0;
    for (int i = 0; i < 4*S + 20; i++) begin
      @(negedge clk);
      chk(rst_out == ~rst_n_out, "R6", rst_out, ~rst_n_out);
      if (rst_n_out == 1'b0) n++;
      else break;
    end
  endtask

  task automatic t_poweron;
    int n;
    rst = 1; supply_ok = 1; mr_n = 1;
    repeat (3) @(negedge clk);
    chk(rst_n_out == 0 && rst_out == 1, "R7 reset state", rst_n_out, 0);
    rst = 0;
    meas(n);
    chk(n == S, "R7 R2 power-on stretch", n, S);
  endtask

  task automatic t_poweron_late_supply;
    int n;
    @(negedge clk); rst = 1; supply_ok = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < S + 4; i++) begin
      @(negedge clk); chk_active("R7 waits for supply");
    end
    supply_ok = 1;
    meas(n);
    chk(n == S, "R7 stretch after supply", n, S);
  endtask

  task automatic t_brownout;
    int n;
    @(negedge clk); supply_ok = 0;
    @(negedge clk); chk_active("R1 asserted next edge");
    repeat (3) begin @(negedge clk); chk_active("R1 held"); end
    supply_ok = 1;
    meas(n);
    chk(n == S, "R2 stretch length", n, S);
  endtask

  task automatic t_restart;
    int n;
    @(negedge clk); supply_ok = 0;
    @(negedge clk); supply_ok = 1;
    repeat (5) begin @(negedge clk); chk_active("R5 mid stretch"); end
    supply_ok = 0;
    @(negedge clk); chk_active("R5 brownout in stretch");
    supply_ok = 1;
    meas(n);
    chk(n == S, "R5 restarted stretch", n, S);
  endtask

  task automatic t_last_cycle;
    int n;
    @(negedge clk); supply_ok = 0;
    @(negedge clk); supply_ok = 1;
    for (int j = 1; j < S; j++) begin
      @(negedge clk); chk_active("R5 before end");
    end
    @(negedge clk); chk_active("R5 last stretch cycle");
    supply_ok = 0;
    @(negedge clk); chk_active("R5 collision keeps reset");
    supply_ok = 1;
    meas(n);
    chk(n == S, "R5 full interval after collision", n, S);
  endtask

  task automatic t_manual;
    int n;
    @(negedge clk); mr_n = 0;
    repeat (3) @(negedge clk);
    chk_active("R4 manual asserted");
    repeat (6) begin @(negedge clk); chk_active("R4 manual held"); end
    mr_n = 1;
    meas(n);
    chk(n == S + 2, "R4 R3 manual stretch", n, S + 2);
  endtask

  task automatic t_bounce;
    int n;
    @(negedge clk); mr_n = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      mr_n = ~mr_n;
      repeat ((k % 3) + 1) begin @(negedge clk); chk_active("R8 bounce"); end
    end
    mr_n = 0;
    @(negedge clk); chk_active("R8 bounce");
    mr_n = 1;
    meas(n);
    chk(n == S + 2, "R8 single pulse after bounce", n, S + 2);
  endtask

  task automatic t_both;
    int n;
    @(negedge clk); mr_n = 0; supply_ok = 0;
    repeat (4) @(negedge clk);
    supply_ok = 1;
    repeat (5) begin @(negedge clk); chk_active("R9 manual still held"); end
    mr_n = 1;
    meas(n);
    chk(n == S + 2, "R9 timed from later cause", n, S + 2);
    @(negedge clk); mr_n = 0; supply_ok = 0;
    repeat (4) @(negedge clk);
    mr_n = 1;
    repeat (5) begin @(negedge clk); chk_active("R9 supply still bad"); end
    supply_ok = 1;
    meas(n);
    chk(n == S, "R9 supply clears last", n, S);
  endtask

  task automatic t_same_cycle;
    int n;
    @(negedge clk); mr_n = 0; supply_ok = 0;
    repeat (4) @(negedge clk);
    mr_n = 1; supply_ok = 1;
    meas(n);
    chk(n == S + 2, "R9 R3 simultaneous release", n, S + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_poweron();
    t_brownout();
    t_restart();
    t_last_cycle();
    t_manual();
    t_bounce();
    t_both();
    t_same_cycle();
    t_poweron_late_supply();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule